// File: doc/BRIEF.md
# DMA Controller Hub: Global Control and Interrupt Aggregation

This block is the controller-wide register set shared by every channel of a multi-channel DMA engine. It sits on a 32-bit memory-mapped register bus. It keeps a global enable that fans out to all channels. It also keeps two sticky global flags, one for address errors and one for halted transfers; any channel can raise either of them. Completion pulses from the channels collect in a one-bit-per-channel pending register, and the OR of that register drives a single interrupt line.

Software starts descriptor processing on a channel by writing a one to that channel's bit in a write-one-to-set doorbell register. The doorbell stays raised until the channel acknowledges it. Software clears pending bits with a read-modify-write: it writes the register back with zeros in the bits to clear. The block also decodes which 32-byte channel register window a bus address falls into, so that the channel register files can share the bus.

Register offsets (byte addresses): 0x1000 is global control, 0x1004 is interrupt pending, 0x100c is doorbell set.

Top module: `dma_ctrl_hub`

## Requirements
- R1: After reset, glb_en, irq and every doorbell bit are 0, and reads of 0x1000 and 0x1004 return 0.
- R2: A write to 0x1000 loads bit 0 into the global enable. From the next cycle, glb_en and read bit 0 of 0x1000 show the written value, both for a 1 and for a 0.
- R3: Read bit 2 of 0x1000 (error) is set in the cycle after any chan_err bit is high. It stays set until a write to 0x1000 with bit 2 at 0. A write with bit 2 at 1 leaves it unchanged. A channel report in the same cycle as a clearing write wins.
- R4: Read bit 3 of 0x1000 (halt) follows the same sticky rules as R3, with chan_halt in place of chan_err.
- R5: Read bits 31:4 and bit 1 of 0x1000 are always 0, whatever was written.
- R6: A chan_done pulse on channel n while chan_irq_en[n] is 1 sets bit n of 0x1004 in the next cycle. A pulse while chan_irq_en[n] is 0 has no effect.
- R7: A write to 0x1004 clears every pending bit written as 0 and keeps every bit written as 1. A completion pulse in the same cycle as a clearing write wins.
- R8: irq is 1 exactly when at least one pending bit is 1. It changes in the same cycle as the pending register.
- R9: A write to 0x100c raises doorbell[n] in the next cycle for each data bit n written as 1. Bits written as 0 do not change the doorbell.
- R10: A doorbell bit falls in the cycle after chan_ack for that channel. A set and an acknowledge in the same cycle leave the bit raised.
- R11: win_chan equals address bits 5 upward (address divided by 32, truncated to the channel index width). win_hit is 1 exactly when the address is below NCH times 32.
- R12: Bus cycles with bus_sel at 0, and reads, change no state. Reads of any offset other than 0x1000 and 0x1004 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| chan_done | input | NCH | Per-channel completion pulse |
| chan_irq_en | input | NCH | Per-channel interrupt enable |
| chan_err | input | NCH | Per-channel address error report |
| chan_halt | input | NCH | Per-channel halt report |
| chan_ack | input | NCH | Channel has started descriptor fetch |
| doorbell | output | NCH | Per-channel descriptor start request |
| irq | output | 1 | Combined interrupt |
| glb_en | output | 1 | Global enable to the channels |
| win_chan | output | CHW | Channel index of the addressed window |
| win_hit | output | 1 | Address lies in a channel window |

## Verification
Every register result is due one clock edge after the write or channel pulse that causes it. Read data, irq, win_chan and win_hit follow their sources in the same cycle, with no register in between. The bench applies each stimulus shortly after a rising edge. It then waits for exactly one more rising edge before sampling register effects, and it samples combinational outputs a nanosecond after changing the address. Same-cycle collisions (set against clear, set against acknowledge) are driven in one shared cycle so that the priority shows at the next sample.

// File: rtl/dma_ctrl_hub.sv
module dma_ctrl_hub #(
  parameter int NCH = 32,
  parameter int AW  = 13,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] chan_done,
  input  logic [NCH-1:0] chan_irq_en,
  input  logic [NCH-1:0] chan_err,
  input  logic [NCH-1:0] chan_halt,
  input  logic [NCH-1:0] chan_ack,
  output logic [NCH-1:0] doorbell,
  output logic           irq,
  output logic           glb_en,
  output logic [CHW-1:0] win_chan,
  output logic           win_hit
);
  localparam logic [AW-1:0] OFS_CTRL = AW'(13'h1000);
  localparam logic [AW-1:0] OFS_PEND = AW'(13'h1004);
  localparam logic [AW-1:0] OFS_DBS  = AW'(13'h100c);
  localparam int WIN_END = NCH * 32;

  logic           en_q, err_q, hlt_q;
  logic [NCH-1:0] pend_q, db_q;

  wire wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  wire wr_pend = bus_sel && bus_wr && (bus_addr == OFS_PEND);
  wire wr_dbs  = bus_sel && bus_wr && (bus_addr == OFS_DBS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      hlt_q  <= 1'b0;
      pend_q <= '0;
      db_q   <= '0;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata[0];
      err_q  <= (wr_ctrl ? (err_q & bus_wdata[2]) : err_q) | (|chan_err);
      hlt_q  <= (wr_ctrl ? (hlt_q & bus_wdata[3]) : hlt_q) | (|chan_halt);
      pend_q <= (wr_pend ? (pend_q & bus_wdata[NCH-1:0]) : pend_q) | (chan_done & chan_irq_en);
      db_q   <= (db_q & ~chan_ack) | (wr_dbs ? bus_wdata[NCH-1:0] : '0);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CTRL) bus_rdata = {28'd0, hlt_q, err_q, 1'b0, en_q};
    else if (bus_addr == OFS_PEND) bus_rdata = 32'(pend_q);
  end

  assign doorbell = db_q;
  assign irq      = |pend_q;
  assign glb_en   = en_q;
  assign win_chan = bus_addr[5 +: CHW];
  assign win_hit  = int'(bus_addr) < WIN_END;
endmodule

module dma_ctrl_hub_chk #(
  parameter int NCH = 32,
  parameter int AW  = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] chan_done,
  input logic [NCH-1:0] chan_irq_en,
  input logic [NCH-1:0] chan_err,
  input logic [NCH-1:0] chan_ack,
  input logic [NCH-1:0] doorbell,
  input logic           irq,
  input logic           glb_en
);
  wire w_ctrl = bus_sel && bus_wr && (bus_addr == AW'(13'h1000));
  wire w_dbs  = bus_sel && bus_wr && (bus_addr == AW'(13'h100c));

  a_r2_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
    w_ctrl |=> (glb_en == $past(bus_wdata[0])));

  a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !w_ctrl |=> $stable(glb_en));

  a_r3_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_err) |=> ((bus_addr != AW'(13'h1000)) || bus_rdata[2]));

  a_r6_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_done & chan_irq_en) != '0) |=> irq);

  a_r9_db_set: assert property (@(posedge clk) disable iff (!rst_n)
    w_dbs |=> ((doorbell & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  a_r10_db_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !w_dbs |=> ((doorbell & $past(chan_ack)) == '0));
endmodule

bind dma_ctrl_hub dma_ctrl_hub_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/sim_dma_ctrl_hub.sv
`timescale 1ns/1ps
module sim_dma_ctrl_hub;
  localparam int NCH = 8;
  localparam int AW  = 13;
  localparam int CHW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] chan_done = '0, chan_irq_en = '0, chan_err = '0, chan_halt = '0, chan_ack = '0;
  logic [NCH-1:0] doorbell;
  logic irq, glb_en, win_hit;
  logic [CHW-1:0] win_chan;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  dma_ctrl_hub #(.NCH(NCH), .AW(AW)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [NCH-1:0] model;
    #22 rst_n = 1;
    step();
    // R1
    chk("R1 glb_en", glb_en, 0);
    chk("R1 irq", irq, 0);
    chk("R1 doorbell", doorbell, 0);
    rd(13'h1000, d); chk("R1 ctrl", d, 0);
    rd(13'h1004, d); chk("R1 pend", d, 0);

    // R2, R5
    bus_write(13'h1000, 32'hffff_fff3);
    chk("R2 en on", glb_en, 1);
    rd(13'h1000, d); chk("R2 readback on / R5 zeros", d, 32'h1);
    bus_write(13'h1000, 32'h0);
    rd(13'h1000, d); chk("R2 readback off", d, 32'h0);
    chk("R2 en off", glb_en, 0);

    // R12: unselected write and read have no effect
    bus_sel = 0; bus_wr = 1; bus_addr = 13'h1000; bus_wdata = 1; step(); bus_wr = 0;
    chk("R12 unselected write", glb_en, 0);
    bus_sel = 1; bus_wr = 0; bus_addr = 13'h100c; bus_wdata = 32'hff; step(); bus_sel = 0;
    chk("R12 read no doorbell", doorbell, 0);
    rd(13'h1008, d); chk("R12 unmapped read", d, 0);
    rd(13'h0040, d); chk("R12 window read", d, 0);

    // R3 / R4 sweep over every channel
    for (int k = 0; k < NCH; k++) begin
      chan_err = NCH'(1) << k; step(); chan_err = '0;
      rd(13'h1000, d); chk("R3 err set", d[2], 1);
      bus_write(13'h1000, 32'h4);
      rd(13'h1000, d); chk("R3 err kept by 1", d[2], 1);
      bus_write(13'h1000, 32'h0);
      rd(13'h1000, d); chk("R3 err cleared by 0", d[2], 0);
      chan_halt = NCH'(1) << k; step(); chan_halt = '0;
      step();
      rd(13'h1000, d); chk("R4 halt sticky", d[3], 1);
      bus_write(13'h1000, 32'h8);
      rd(13'h1000, d); chk("R4 halt kept by 1", d[3], 1);
      bus_write(13'h1000, 32'h0);
      rd(13'h1000, d); chk("R4 halt cleared", d, 0);
    end
    // R3/R4 collision: report beats clear
    bus_sel = 1; bus_wr = 1; bus_addr = 13'h1000; bus_wdata = 0;
    chan_err = 8'h10; chan_halt = 8'h01; step();
    bus_sel = 0; bus_wr = 0; chan_err = '0; chan_halt = '0;
    rd(13'h1000, d); chk("R3 R4 set wins", d, 32'hc);
    bus_write(13'h1000, 32'h0);

    // R6, R8: per-channel completion with and without enable
    for (int k = 0; k < NCH; k++) begin
      chan_irq_en = ~(NCH'(1) << k); chan_done = NCH'(1) << k; step(); chan_done = '0;
      rd(13'h1004, d); chk("R6 disabled no effect", d, 0);
      chk("R8 irq low", irq, 0);
      chan_irq_en = '1; chan_done = NCH'(1) << k; step(); chan_done = '0;
      rd(13'h1004, d); chk("R6 pending bit", d, 32'(NCH'(1) << k));
      chk("R8 irq high", irq, 1);
      bus_write(13'h1004, 32'h0);
      chk("R8 irq after clear", irq, 0);
    end

    // R7: exhaustive clear masks from a full pending register
    for (int m = 0; m < 256; m++) begin
      chan_done = '1; step(); chan_done = '0;
      bus_write(13'h1004, 32'(m));
      rd(13'h1004, d); chk("R7 clear mask", d, 32'(m));
      chk("R8 irq or", irq, (m != 0));
      bus_write(13'h1004, 32'h0);
    end
    // R7 collision
    chan_done = '1; step();
    bus_sel = 1; bus_wr = 1; bus_addr = 13'h1004; bus_wdata = 0; chan_done = 8'h24; step();
    bus_sel = 0; bus_wr = 0; chan_done = '0;
    rd(13'h1004, d); chk("R7 set wins", d, 32'h24);
    bus_write(13'h1004, 32'h0);

    // R9, R10: exhaustive doorbell patterns
    model = '0;
    for (int m = 0; m < 256; m++) begin
      bus_write(13'h100c, 32'(m));
      model = model | NCH'(m);
      chk("R9 doorbell set", doorbell, model);
      chan_ack = NCH'(m * 37); step(); chan_ack = '0;
      model = model & ~NCH'(m * 37);
      chk("R10 ack clears", doorbell, model);
    end
    bus_write(13'h100c, 32'h0);
    chk("R9 zero write no change", doorbell, model);
    // R10 collision
    bus_sel = 1; bus_wr = 1; bus_addr = 13'h100c; bus_wdata = 32'h81; chan_ack = 8'h81; step();
    bus_sel = 0; bus_wr = 0; chan_ack = '0;
    chk("R10 set beats ack", doorbell & 8'h81, 8'h81);
    chan_ack = '1; step(); chan_ack = '0;
    chk("R10 all acked", doorbell, 0);

    // R11: window decode sweep
    for (int a = 0; a < NCH * 32 + 64; a += 4) begin
      bus_addr = AW'(a); #1;
      chk("R11 win_chan", win_chan, (a / 32) % NCH);
      chk("R11 win_hit", win_hit, (a < NCH * 32));
    end
    bus_addr = 13'h1000; #1;
    chk("R11 ctrl not window", win_hit, 0);

    summary();
  end
endmodule